// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Gap and Address Marking

This block shifts 8-bit characters onto a single serial line. Each character goes out as a low start bit, eight data bits with the least significant bit first, one parity bit and one high stop bit. Every bit boundary falls on a one-cycle baud-tick enable that an outside rate generator supplies. A one-entry holding register takes characters from a write port. The block moves a character into the shifter as soon as the line is free, so characters can go out back to back.

A programmable idle gap of 0 to 255 bit times can follow each stop bit. This gap lets a slow far end keep up. When the gap is nonzero, the ready flag and the empty flag assert later than usual. Two of the parity-mode codes select multidrop operation. In that mode the parity slot carries an address/data marker instead of a parity value, and a send-address strobe marks the next character loaded as an address. All other mode codes give even parity.

Top module: `uart_tg_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: The line level a character drives is, in order: 0 (start), data bit 0 up to data bit 7, the parity slot, then 1 (stop). Each of these lasts exactly from one baud tick to the next. `txd` changes only in the cycle that follows a cycle with `baud_tick` high.
- R3: When `par_mode` is any code other than 3'b110 and 3'b111, the parity slot holds even parity. That is, it equals the XOR of the eight data bits.
- R4: When `par_mode` is 3'b110 or 3'b111 (multidrop), a character not marked as an address has 0 in its parity slot.
- R5: A one-cycle pulse on `send_addr` is remembered until the next character moves from the holding register into the shifter. That character carries 1 in its parity slot when multidrop is selected. The memory then clears, so the following character is data again.
- R6: After the stop bit, `txd` stays at 1 for `tg_val` further bit periods before the next start bit can begin.
- R7: With `tg_val` = 0, `tx_ready` returns to 1 in the cycle after the holding register moves into the shifter. Back-to-back characters have no idle bit between them. `tx_empty` rises at the end of the stop bit when nothing is waiting.
- R8: With `tg_val` nonzero, `tx_ready` returns to 1 only at the end of the start bit of the character just taken from the holding register.
- R9: With `tg_val` nonzero, `tx_empty` stays at 0 until the whole idle gap has elapsed.
- R10: A write when `tx_ready` is 0 is ignored, and the character already held goes out unchanged. A write that is accepted drops `tx_ready` and `tx_empty` to 0 in the next cycle.
- R11: The gap count is 8 bits wide, and a value of 255 produces a gap of 255 bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle bit-period enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| send_addr | input | 1 | Marks the next loaded character as an address |
| par_mode | input | 3 | Parity mode; 3'b110 and 3'b111 select multidrop |
| tg_val | input | 8 | Idle gap in bit periods after each stop bit |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Shifter, gap and holding register all idle |

## Verification
A wrong bit counter or shifter shows up on `txd` within one bit period as a misplaced or wrong level. A lost or stale address marker shows up in the parity slot of that character or of the next one. A gap counter that is off by one moves the next start bit, and the rise of `tx_empty`, by one whole tick interval. A bad ready/empty sequence is visible within a cycle of the load or of the start-bit boundary. The bench compares all three outputs with a behavioural frame model on every clock, so each of these faults is caught in the cycle where it first appears.

// File: rtl/uart_tg_pkg.sv
package uart_tg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_GAP
  } tx_state_e;

  // Multidrop is selected by the two top mode codes
  function automatic logic is_multidrop(input logic [2:0] mode);
    return mode[2:1] == 2'b11;
  endfunction

  function automatic logic slot_bit(input logic [7:0] data, input logic [2:0] mode,
                                    input logic addr);
    return is_multidrop(mode) ? addr : ^data;
  endfunction
endpackage

// File: rtl/uart_tg_hold.sv
module uart_tg_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              load,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              send_addr,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              addr_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      addr_pend  <= 1'b0;
    end else begin
      if (accept) begin
        hold_valid <= 1'b1;
        hold_data  <= wr_data;
      end else if (load) begin
        hold_valid <= 1'b0;
      end
      if (send_addr)
        addr_pend <= 1'b1;
      else if (load)
        addr_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tg_gap.sv
module uart_tg_gap #(
  parameter int TG_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [TG_W-1:0] ld_val,
  input  logic            dec,
  output logic            last
);
  logic [TG_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (ld)
      cnt_q <= ld_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == TG_W'(1));
endmodule

// File: rtl/uart_tg_tx.sv
module uart_tg_tx
  import uart_tg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TG_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              send_addr,
  input  logic [2:0]        par_mode,
  input  logic [TG_W-1:0]   tg_val,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q, state_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [DATA_W-1:0] shift_q, shift_n;
  logic              par_q, par_n;
  logic              wait_q;
  logic              load, accept, gap_ld, gap_dec, gap_last;
  logic              hold_valid, hold_valid_n, addr_pend;
  logic [DATA_W-1:0] hold_data;
  logic              tg_zero;

  assign accept       = wr_en && tx_ready;
  assign tg_zero      = (tg_val == '0);
  assign hold_valid_n = accept || (hold_valid && !load);

  uart_tg_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .accept(accept), .load(load), .wr_data(wr_data),
    .send_addr(send_addr), .hold_valid(hold_valid), .hold_data(hold_data),
    .addr_pend(addr_pend)
  );

  uart_tg_gap #(.TG_W(TG_W)) u_gap (
    .clk(clk), .rst(rst), .ld(gap_ld), .ld_val(tg_val), .dec(gap_dec), .last(gap_last)
  );

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    shift_n = shift_q;
    par_n   = par_q;
    load    = 1'b0;
    gap_ld  = 1'b0;
    gap_dec = 1'b0;
    if (baud_tick) begin
      case (state_q)
        ST_IDLE:  load = hold_valid;
        ST_START: begin
          state_n = ST_DATA;
          bit_n   = '0;
        end
        ST_DATA: begin
          shift_n = shift_q >> 1;
          if (bit_q == BIT_W'(DATA_W - 1)) state_n = ST_PAR;
          else bit_n = bit_q + 1'b1;
        end
        ST_PAR:   state_n = ST_STOP;
        ST_STOP: begin
          if (!tg_zero) begin
            state_n = ST_GAP;
            gap_ld  = 1'b1;
          end else if (hold_valid) load = 1'b1;
          else state_n = ST_IDLE;
        end
        ST_GAP: begin
          gap_dec = 1'b1;
          if (gap_last) begin
            if (hold_valid) load = 1'b1;
            else state_n = ST_IDLE;
          end
        end
        default:  state_n = ST_IDLE;
      endcase
    end
    if (load) begin
      state_n = ST_START;
      shift_n = hold_data;
      par_n   = slot_bit(hold_data, par_mode, addr_pend);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      shift_q  <= '0;
      par_q    <= 1'b0;
      wait_q   <= 1'b0;
      txd      <= 1'b1;
      tx_ready <= 1'b1;
      tx_empty <= 1'b1;
    end else begin
      state_q  <= state_n;
      bit_q    <= bit_n;
      shift_q  <= shift_n;
      par_q    <= par_n;
      tx_empty <= (state_n == ST_IDLE) && !hold_valid_n;
      case (state_n)
        ST_START: txd <= 1'b0;
        ST_DATA:  txd <= shift_n[0];
        ST_PAR:   txd <= par_n;
        default:  txd <= 1'b1;
      endcase
      if (accept) begin
        tx_ready <= 1'b0;
      end else if (load) begin
        if (tg_zero) tx_ready <= 1'b1;
        else wait_q <= 1'b1;
      end else if (baud_tick && state_q == ST_START && wait_q) begin
        tx_ready <= 1'b1;
        wait_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_tg_tx_chk.sv
module uart_tg_tx_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic wr_en,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk)
    if (rst_q) AST_RESET_IDLE: assert (txd && tx_ready && tx_empty); // R1

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (txd != $past(txd)) |-> $past(baud_tick)); // R2

  AST_EMPTY_IMPLIES_READY: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_ready); // R7

  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd); // R9

  AST_ACCEPT_DROPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_ready) |=> (!tx_ready && !tx_empty)); // R10
endmodule

bind uart_tg_tx uart_tg_tx_chk u_chk (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
  .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
);

// File: tb/uart_tg_tx_test.sv
module uart_tg_tx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       send_addr = 1'b0;
  logic [2:0] par_mode = '0;
  logic [7:0] tg_val = '0;
  logic       txd, tx_ready, tx_empty;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  uart_tg_tx uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .send_addr(send_addr), .par_mode(par_mode), .tg_val(tg_val),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #5 clk = ~clk;

  // Tick on every fourth cycle, driven away from the active edge
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // Behavioural frame model: a frame is a list of line levels plus a gap length
  byte unsigned hq[$];
  bit  [10:0]   fr;
  int           pos, flen;
  bit           active, m_ready, m_wait, m_pend, m_line, m_empty;

  always @(posedge clk) begin
    bit acc, was_pend, pbit;
    byte unsigned d;
    if (rst) begin
      hq.delete();
      active = 0; pos = 0; flen = 0; m_ready = 1; m_wait = 0; m_pend = 0;
    end else begin
      acc = wr_en && m_ready;
      was_pend = m_pend;
      if (baud_tick && active) begin
        if (pos == flen - 1) active = 0;
        else begin
          pos++;
          if (pos == 1 && m_wait) begin m_ready = 1; m_wait = 0; end
        end
      end
      if (baud_tick && !active && hq.size() > 0) begin
        d = hq.pop_front();
        pbit = (par_mode[2:1] == 2'b11) ? was_pend : ^d;
        fr = {1'b1, pbit, d, 1'b0};
        flen = 11 + tg_val;
        pos = 0;
        active = 1;
        m_pend = 0;
        if (tg_val == 0) m_ready = 1; else m_wait = 1;
      end
      if (send_addr) m_pend = 1;
      if (acc) begin hq.push_back(wr_data); m_ready = 0; end
    end
    m_line  = active ? ((pos < 11) ? fr[pos] : 1'b1) : 1'b1;
    m_empty = !active && hq.size() == 0;
  end

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("txd", txd, m_line);
      check("tx_ready", tx_ready, m_ready);
      check("tx_empty", tx_empty, m_empty);
    end
  end

  task automatic put(input byte unsigned d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic wait_empty();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset txd", txd, 1'b1);
    check("R1 reset ready", tx_ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 empty after reset", tx_empty, 1'b1);

    // R2 R3 even parity, R7 back-to-back with no gap
    cur_req = "R3";
    par_mode = 3'b000; tg_val = 8'd0;
    put(8'hA5);
    check("R10 ready drops after write", tx_ready, 1'b0);
    wait_ready();
    cur_req = "R7";
    put(8'h01);
    wait_ready();
    put(8'h80);
    wait_empty();

    // R4 multidrop data
    cur_req = "R4";
    par_mode = 3'b110;
    put(8'h3C);
    wait_empty();

    // R5 address marker then data
    cur_req = "R5";
    par_mode = 3'b111;
    @(negedge clk); send_addr = 1'b1;
    @(negedge clk); send_addr = 1'b0;
    put(8'h55);
    wait_ready();
    put(8'h55);
    wait_empty();

    // R6 R8 R9 short gap
    cur_req = "R8";
    par_mode = 3'b010; tg_val = 8'd3;
    put(8'h0F);
    wait_ready();
    cur_req = "R6";
    put(8'hF0);
    wait_ready();
    cur_req = "R9";
    wait_empty();

    // R10 write while busy is dropped
    cur_req = "R10";
    tg_val = 8'd0;
    put(8'h11);
    check("R10 ready low before second write", tx_ready, 1'b0);
    put(8'h22);
    wait_empty();

    // R11 largest gap
    cur_req = "R11";
    tg_val = 8'd255;
    put(8'h80);
    wait_ready();
    put(8'h81);
    wait_empty();

    finish_run();
  end
endmodule